// File: doc/BRIEF.md
# Synthesizer Configuration Port

This block is the programming front end of a clock synthesizer. Its configuration has three fields: a 3-bit test-output select, a 2-bit post-divider code and a 9-bit feedback-divider code. A host can write the configuration in two ways. It can shift a 14-bit word in one bit at a time on a slow serial clock and then pulse a serial load strobe. It can also present the feedback and post-divider codes on parallel pins and pulse a parallel load strobe. Both paths write one shared configuration register. That register drives the decoded fields as registered outputs.

The serial clock, serial data and both strobes are asynchronous to the system clock. Each passes through a synchronizer, and the block acts on the rising edges it detects there. If both strobes are detected in the same cycle, the parallel load wins. A load that carries a feedback code outside the permitted range leaves the register untouched and raises a one-cycle reject pulse. A readback output shows the oldest bit in the shift register. It follows that bit only while the parallel strobe is high, which holds the readback latch in reset. At all other times it keeps its last value.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, the outputs are as follows: `test_sel` = 0, `post_div` = 0, `fb_div` = 200 (binary 011001000), `cfg_reject` = 0 and `scan_out` = 0.
- R2: Each rising edge of `ser_clk` shifts one bit into a 14-bit register. On a `ser_load` rising edge, the register is applied to the outputs. The first bit shifted lands in `test_sel[2]`, then `test_sel[1:0]`, then `post_div[1:0]`, then `fb_div[8]` down to `fb_div[0]`, so the last bit shifted lands in `fb_div[0]`.
- R3: `ser_data` is sampled at the synchronized rising edge of `ser_clk`. If more than 14 bits are shifted before a load, only the last 14 count.
- R4: On a `par_load` rising edge, `fb_div` takes the value of `par_m` and `post_div` takes the value of `par_n`. `test_sel` keeps its value.
- R5: If the rising edges of both strobes are detected in the same cycle, only the parallel load takes effect. The shifted word is not applied by that strobe.
- R6: A load whose feedback code is below 160 or above 510 leaves all three fields unchanged. It pulses `cfg_reject` high for exactly one cycle. The codes 160 and 510 are both accepted.
- R7: A strobe rise sampled at clock edge t0 updates the outputs at edge t0+2. At edge t0+1 the outputs still show the old values.
- R8: While the synchronized `par_load` is high, `scan_out` follows the oldest shift-register bit, which is the first bit shifted. While it is low, `scan_out` holds its value.
- R9: Without a load strobe, shifting does not change `test_sel`, `post_div` or `fb_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe; acts on its rising edge |
| par_load | input | 1 | Parallel load strobe; also holds the readback latch in reset while high |
| par_m | input | 9 | Parallel feedback-divider code |
| par_n | input | 2 | Parallel post-divider code |
| test_sel | output | 3 | Latched test-output select |
| post_div | output | 2 | Latched post-divider code |
| fb_div | output | 9 | Latched feedback-divider code |
| cfg_reject | output | 1 | One-cycle pulse when a load is refused |
| scan_out | output | 1 | Readback of the oldest shift-register bit |

## Verification
The two functions that can fall in the same cycle are the serial load and the parallel load. The bench provokes this by raising both strobes on the same clock phase, after it has shifted a distinct word into the register. Both edges then reach the detectors together. The result passes only if the fields match the parallel pins and the earlier test select. A later serial strobe on its own must then apply the retained shifted word. This shows that the collision suppressed the serial load without corrupting the shift register.

// File: rtl/synth_cfg_pkg.sv
// Shared field widths and the packed configuration word.
// Assumes the fixed field order test select, post divider, feedback divider (MSB first).
package synth_cfg_pkg;
    localparam int T_W    = 3;
    localparam int N_W    = 2;
    localparam int M_W    = 9;
    localparam int WORD_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] tsel;
        logic [N_W-1:0] ndiv;
        logic [M_W-1:0] mdiv;
    } cfg_word_t;
endpackage

// File: rtl/sync_chain.sv
// Multi-bit, multi-stage flop synchronizer.
// Assumes each bit is quasi-static over several clk periods; bits are synchronized independently.
module sync_chain #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Each later stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
// Serial shift register for the configuration word; new bits enter at the LSB.
// Assumes shift_en is a single-cycle pulse per serial clock edge.
module cfg_shifter
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    // Shift left by one on every enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_latch.sv
// Configuration register shared by the serial and parallel load paths.
// Parallel wins a same-cycle collision; out-of-range feedback codes are refused.
// Assumes ser_evt and par_evt are single-cycle pulses.
module cfg_latch
    import synth_cfg_pkg::*;
#(
    parameter int M_MIN   = 160,
    parameter int M_MAX   = 510,
    parameter int M_RESET = 200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_evt,
    input  logic           par_evt,
    input  cfg_word_t      ser_word,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output cfg_word_t      cfg,
    output logic           reject
);
    localparam logic [M_W-1:0] MIN_C = M_W'(M_MIN);
    localparam logic [M_W-1:0] MAX_C = M_W'(M_MAX);
    localparam logic [M_W-1:0] RST_C = M_W'(M_RESET);

    cfg_word_t cand;
    logic      upd;
    logic      in_range;

    // Pick the candidate word: the parallel path keeps the current test select.
    always_comb begin
        upd = ser_evt | par_evt;
        if (par_evt) cand = '{tsel: cfg.tsel, ndiv: par_n, mdiv: par_m};
        else         cand = ser_word;
        in_range = (cand.mdiv >= MIN_C) && (cand.mdiv <= MAX_C);
    end

    // Commit an in-range candidate, otherwise flag the refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '{tsel: '0, ndiv: '0, mdiv: RST_C};
            reject <= 1'b0;
        end else begin
            reject <= upd & ~in_range;
            if (upd && in_range) cfg <= cand;
        end
    end
endmodule

// File: rtl/synth_cfg_port.sv
// Top of the synthesizer configuration port: synchronizes the serial and strobe
// inputs, detects their rising edges, and drives the shifter, the latch and the readback.
// Assumes all serial and strobe inputs stay stable for more than SYNC_STAGES+1 clk periods.
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int M_MIN       = 160,
    parameter int M_MAX       = 510,
    parameter int M_RESET     = 200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [T_W-1:0] test_sel,
    output logic [N_W-1:0] post_div,
    output logic [M_W-1:0] fb_div,
    output logic           cfg_reject,
    output logic           scan_out
);
    logic [3:0]        lvl;
    logic [2:0]        prev_q;
    logic              sck_rise;
    logic              ser_evt;
    logic              par_evt;
    logic              par_lvl;
    logic [WORD_W-1:0] sr_word;
    cfg_word_t         cfg;

    sync_chain #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({par_load, ser_load, ser_data, ser_clk}),
        .sync_out (lvl)
    );

    // Remember last synchronized levels of the clock and both strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= {lvl[3], lvl[2], lvl[0]};
    end

    assign sck_rise = lvl[0] & ~prev_q[0];
    assign ser_evt  = lvl[2] & ~prev_q[1];
    assign par_evt  = lvl[3] & ~prev_q[2];
    assign par_lvl  = lvl[3];

    cfg_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sck_rise),
        .bit_in   (lvl[1]),
        .word     (sr_word)
    );

    cfg_latch #(.M_MIN(M_MIN), .M_MAX(M_MAX), .M_RESET(M_RESET)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_evt  (ser_evt),
        .par_evt  (par_evt),
        .ser_word (cfg_word_t'(sr_word)),
        .par_m    (par_m),
        .par_n    (par_n),
        .cfg      (cfg),
        .reject   (cfg_reject)
    );

    // Readback latch: transparent to the oldest bit while the parallel strobe holds it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       scan_out <= 1'b0;
        else if (par_lvl) scan_out <= sr_word[WORD_W-1];
    end

    assign test_sel = cfg.tsel;
    assign post_div = cfg.ndiv;
    assign fb_div   = cfg.mdiv;
endmodule

// File: rtl/synth_cfg_port_chk.sv
// Property checker for synth_cfg_port, attached by bind below.
module synth_cfg_port_chk #(
    parameter int M_MIN = 160,
    parameter int M_MAX = 510
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] test_sel,
    input logic [1:0] post_div,
    input logic [8:0] fb_div,
    input logic       cfg_reject,
    input logic       scan_out,
    input logic       ser_evt,
    input logic       par_evt,
    input logic       par_lvl
);
    // R6
    fb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_div) >= M_MIN) && (int'(fb_div) <= M_MAX));

    // R6
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> ($stable(fb_div) && $stable(post_div) && $stable(test_sel)));

    // R5
    par_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_evt && par_evt) |=> $stable(test_sel));

    // R9
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_evt || par_evt) |=> ($stable(fb_div) && $stable(post_div) && $stable(test_sel)));

    // R8
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_lvl |=> $stable(scan_out));
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_sel   (test_sel),
    .post_div   (post_div),
    .fb_div     (fb_div),
    .cfg_reject (cfg_reject),
    .scan_out   (scan_out),
    .ser_evt    (ser_evt),
    .par_evt    (par_evt),
    .par_lvl    (par_lvl)
);

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [2:0] test_sel;
    logic [1:0] post_div;
    logic [8:0] fb_div;
    logic       cfg_reject, scan_out;

    int vectors = 0;
    int fails   = 0;
    int rej_seen = 0;

    always #5 clk = ~clk;

    synth_cfg_port u_synth_cfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .test_sel(test_sel), .post_div(post_div), .fb_div(fb_div),
        .cfg_reject(cfg_reject), .scan_out(scan_out)
    );

    // Behavioural reference: input history, shifted word, fields, reject, readback.
    logic [2:0]  hc, hd, hl, hp;
    logic [13:0] m_sr;
    logic [2:0]  m_t;
    logic [1:0]  m_n;
    logic [8:0]  m_m;
    logic        m_rej, m_scan;

    always @(posedge clk) begin
        logic [13:0] old;
        logic [2:0]  ct;
        logic [1:0]  cn;
        logic [8:0]  cm;
        logic        sl, pl;
        if (!rst_n) begin
            hc = '0; hd = '0; hl = '0; hp = '0;
            m_sr = '0; m_t = '0; m_n = '0; m_m = 9'd200; m_rej = 0; m_scan = 0;
        end else begin
            old = m_sr;
            sl  = hl[1] & ~hl[2];
            pl  = hp[1] & ~hp[2];
            if (hc[1] & ~hc[2]) m_sr = {m_sr[12:0], hd[1]};
            m_rej = 0;
            if (sl || pl) begin
                ct = pl ? m_t   : old[13:11];
                cn = pl ? par_n : old[10:9];
                cm = pl ? par_m : old[8:0];
                if (cm >= 9'd160 && cm <= 9'd510) begin
                    m_t = ct; m_n = cn; m_m = cm;
                end else m_rej = 1;
            end
            if (hp[1]) m_scan = old[13];
            hc = {hc[1:0], ser_clk};
            hd = {hd[1:0], ser_data};
            hl = {hl[1:0], ser_load};
            hp = {hp[1:0], par_load};
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 test_sel", test_sel, m_t);
            check("R2 post_div", post_div, m_n);
            check("R2 fb_div", fb_div, m_m);
            check("R6 cfg_reject", cfg_reject, m_rej);
            check("R8 scan_out", scan_out, m_scan);
            if (cfg_reject) rej_seen++;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b; wait_n(2);
        ser_clk = 1'b1; wait_n(4);
        ser_clk = 1'b0; wait_n(4);
    endtask

    task automatic shift_word(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
        logic [13:0] w;
        w = {t, n, m};
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic sload;
        ser_load = 1'b1; wait_n(5);
        ser_load = 1'b0; wait_n(5);
    endtask

    task automatic pload(input logic [8:0] m, input logic [1:0] n);
        par_m = m; par_n = n; wait_n(1);
        par_load = 1'b1; wait_n(5);
        par_load = 1'b0; wait_n(5);
    endtask

    task automatic expect_cfg(input string tag, input int t, input int n, input int m);
        check(tag, test_sel, t);
        check(tag, post_div, n);
        check(tag, fb_div, m);
    endtask

    initial begin
        int r0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        expect_cfg("R1", 0, 0, 200);
        check("R1 reject", cfg_reject, 0);
        check("R1 scan", scan_out, 0);

        // R2 serial word
        shift_word(3'b101, 2'b10, 9'd300);
        sload;
        expect_cfg("R2", 5, 2, 300);

        // R4 parallel load keeps test select
        pload(9'd400, 2'd1);
        expect_cfg("R4", 5, 1, 400);

        // R7 latency: strobe raised before edge t0
        shift_word(3'b010, 2'b01, 9'd220);
        ser_load = 1'b1;
        wait_n(2);
        expect_cfg("R7 before", 5, 1, 400);
        wait_n(1);
        expect_cfg("R7 after", 2, 1, 220);
        wait_n(3);
        ser_load = 1'b0; wait_n(5);

        // R5 collision: parallel wins, shifted word not applied
        shift_word(3'b011, 2'b11, 9'd250);
        par_m = 9'd170; par_n = 2'd0; wait_n(1);
        ser_load = 1'b1; par_load = 1'b1; wait_n(5);
        ser_load = 1'b0; par_load = 1'b0; wait_n(5);
        expect_cfg("R5", 2, 0, 170);
        sload;
        expect_cfg("R5 retained word", 3, 3, 250);

        // R6 refused codes
        r0 = rej_seen;
        shift_word(3'b111, 2'b00, 9'd100);
        sload;
        expect_cfg("R6 low", 3, 3, 250);
        check("R6 pulse", rej_seen - r0, 1);
        r0 = rej_seen;
        pload(9'd511, 2'd2);
        expect_cfg("R6 high", 3, 3, 250);
        check("R6 pulse", rej_seen - r0, 1);
        pload(9'd160, 2'd2);
        expect_cfg("R6 min", 3, 2, 160);
        pload(9'd510, 2'd3);
        expect_cfg("R6 max", 3, 3, 510);

        // R3 extra leading bits are pushed out
        shift_bit(1'b1); shift_bit(1'b1);
        shift_word(3'b001, 2'b00, 9'd480);
        sload;
        expect_cfg("R3", 1, 0, 480);

        // R8 readback follows while parallel strobe high, holds otherwise
        par_m = 9'd300; par_n = 2'd0; wait_n(1);
        par_load = 1'b1; wait_n(5);
        for (int i = 0; i < 14; i++) shift_bit(1'b1);
        check("R8 follow", scan_out, 1);
        par_load = 1'b0; wait_n(5);
        for (int i = 0; i < 14; i++) shift_bit(1'b0);
        check("R8 hold", scan_out, 1);
        // R9 shifting alone leaves the configuration
        expect_cfg("R9", 1, 0, 300);
        par_load = 1'b1; wait_n(6);
        check("R8 follow again", scan_out, 0);
        par_load = 1'b0; wait_n(5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule